// File: doc/BRIEF.md
# Debug Session End and Breakpoint Router

This block closes debug sessions for an on-chip debug unit. It collects trigger events from several comparator channels, a software trigger bit, two external tag pins and a coprocessor software breakpoint. It resolves them by fixed precedence and steers a small state sequencer, which runs from idle through two intermediate states to a final state. It also decides whether the session ends at once or waits for the trace buffer to finish capturing.

When the session ends, the block raises a breakpoint. The breakpoint is routed through a mapping that depends on the breakpoint enable, the debug-mode select, and whether the debug monitor is enabled or active. The result is a single-cycle debug-monitor entry request, a single-cycle software-interrupt request, or nothing. When the session ends at once while tracing is selected, a single-cycle trace-stop pulse tells the trace buffer to stop.

All outputs are registered. An event sampled at a rising edge shows its result on the outputs for the cycle that follows that edge.

Top module: `dbg_session_arb`

## Requirements
- R1: A synchronous active-high reset drives seq_state to 0 and clears mon_req, swi_req and trace_stop. It also discards a pending delayed breakpoint, so a later trace_done pulse raises no request.
- R2: While arm is 1, a seq_step pulse advances seq_state from 0 to 1 and from 1 to 2, and it stays at 2 after that. While arm is 0, seq_step has no effect.
- R3: A trigger with immediate timing ends the session in the cycle after it is sampled. Immediate timing means trace_en is 0, or trace_align is 2'b00 (end) or 2'b11. In that cycle the mapped request is raised, seq_state returns to 0, and trace_stop pulses only when trace_en is 1.
- R4: With trace_en 1 and trace_align 2'b01 (begin) or 2'b10 (mid), a trigger moves seq_state to 3 (final) and raises no request. The breakpoint is held until a trace_done pulse, and the mapped request then appears in the next cycle with seq_state back at 0. A trace_done pulse with nothing pending is ignored.
- R5: sw_trig acts whatever the value of arm. Comparator triggers and comparator tags act only while arm is 1.
- R6: While a delayed breakpoint is pending in state 3, further sw_trig or comp_trig events change nothing.
- R7: A hit on ext_tag_hi or ext_tag_lo ends the session at once, whatever trace_align is. It raises the mapped request, pulses trace_stop when trace_en is 1, returns seq_state to 0, and also ends a pending delayed session.
- R8: An armed comparator tag and an external tag in the same cycle send seq_state to 0 with no request and no trace_stop.
- R9: cop_brk wins over every other source in the same cycle. It raises the mapped request at once, pulses trace_stop when trace_en is 1, returns seq_state to 0 and clears any pending breakpoint.
- R10: The breakpoint maps as follows. If brk_en is 0 there is no request. If brk_en is 1 and brk_to_mon is 0, the request is swi_req. If brk_to_mon is 1 and mon_enabled is 0, the request is also swi_req. If brk_to_mon is 1 and mon_enabled is 1, the request is mon_req.
- R11: When mon_active is 1 in the cycle a breakpoint is generated, no request is raised.
- R12: mon_req and swi_req are never high together, and each request lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Debug unit armed; enables comparator events and seq_step |
| seq_step | input | 1 | Comparator match that advances the sequencer one state |
| comp_trig | input | N_CH | Per-channel comparator trigger into the final state |
| comp_tag | input | N_CH | Per-channel comparator tag hit |
| sw_trig | input | 1 | Software trigger bit event |
| ext_tag_hi | input | 1 | External high tag pin hit |
| ext_tag_lo | input | 1 | External low tag pin hit |
| cop_brk | input | 1 | Coprocessor software breakpoint |
| trace_en | input | 1 | A tracing session is selected |
| trace_align | input | 2 | Trigger alignment: 00 end, 01 begin, 10 mid, 11 end |
| trace_done | input | 1 | Single-cycle pulse: the trace buffer has finished capturing |
| brk_en | input | 1 | Breakpoint enable |
| brk_to_mon | input | 1 | Route breakpoints to the debug monitor when possible |
| mon_enabled | input | 1 | Debug monitor entry is enabled |
| mon_active | input | 1 | Debug monitor firmware is running |
| mon_req | output | 1 | Single-cycle debug monitor entry request |
| swi_req | output | 1 | Single-cycle software interrupt request |
| trace_stop | output | 1 | Single-cycle pulse: stop tracing now |
| seq_state | output | STATE_W | Sequencer state: 0 idle, 3 final |

## Verification
The bench uses the defaults N_CH = 4 and STATE_W = 2. With four channels, comparator events can arrive on a channel other than channel 0, and a comparator tag can land on one channel while an external tag hits in the same cycle. With two state bits, the saturation at state 2 and the jump to final state 3 are both reachable in a few cycles. The mapping table is swept through a vector loop using the software trigger, because that trigger works with the unit disarmed.

// File: rtl/dbgarb_pkg.sv
package dbgarb_pkg;

  localparam int ALIGN_W = 2;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_SWI  = 2'd1,
    ROUTE_MON  = 2'd2
  } route_e;

  typedef enum logic [2:0] {
    EV_IDLE  = 3'd0,
    EV_ABORT = 3'd1,
    EV_CLASH = 3'd2,
    EV_XTAG  = 3'd3,
    EV_TRIG  = 3'd4,
    EV_DONE  = 3'd5,
    EV_STEP  = 3'd6
  } event_e;

  // Decide where a breakpoint goes, given the control bits and monitor state.
  function automatic route_e route_brk(input logic en, input logic to_mon,
                                       input logic mon_en, input logic mon_act);
    route_e r;
    if (!en || mon_act)  r = ROUTE_NONE;
    else if (!to_mon)    r = ROUTE_SWI;
    else if (!mon_en)    r = ROUTE_SWI;
    else                 r = ROUTE_MON;
    return r;
  endfunction

  // Begin and mid alignment wait for the trace to finish; others end at once.
  function automatic logic align_defers(input logic ten, input logic [ALIGN_W-1:0] al);
    return ten && (al == 2'b01 || al == 2'b10);
  endfunction

endpackage

// File: rtl/dbgarb_resolve.sv
module dbgarb_resolve
  import dbgarb_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic            arm,
  input  logic            seq_step,
  input  logic [N_CH-1:0] comp_trig,
  input  logic [N_CH-1:0] comp_tag,
  input  logic            sw_trig,
  input  logic            ext_tag,
  input  logic            cop_brk,
  input  logic            trace_done,
  input  logic            pend,
  output event_e          ev
);

  logic [N_CH-1:0] trig_q;
  logic [N_CH-1:0] tag_q;

  // Comparator channel events count only while the unit is armed.
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign trig_q[i] = comp_trig[i] & arm;
    assign tag_q[i]  = comp_tag[i]  & arm;
  end

  logic comp_any;
  logic tag_any;
  assign comp_any = |trig_q;
  assign tag_any  = |tag_q;

  always_comb begin
    ev = EV_IDLE;
    if (cop_brk)                    ev = EV_ABORT;
    else if (ext_tag && tag_any)    ev = EV_CLASH;
    else if (pend) begin
      if (ext_tag)                  ev = EV_XTAG;
      else if (trace_done)          ev = EV_DONE;
    end
    else if (ext_tag)               ev = EV_XTAG;
    else if (sw_trig || comp_any || tag_any) ev = EV_TRIG;
    else if (seq_step && arm)       ev = EV_STEP;
  end

endmodule

// File: rtl/dbgarb_seq.sv
module dbgarb_seq
  import dbgarb_pkg::*;
#(
  parameter int STATE_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  event_e              ev,
  input  logic                trace_en,
  input  logic [ALIGN_W-1:0]  trace_align,
  output logic [STATE_W-1:0]  state,
  output logic                pend,
  output logic                brk_now,
  output logic                stop_now
);

  localparam logic [STATE_W-1:0] S_IDLE  = '0;
  localparam logic [STATE_W-1:0] S_FINAL = '1;
  localparam logic [STATE_W-1:0] S_LAST  = S_FINAL - 1'b1;

  logic [STATE_W-1:0] state_d;
  logic               pend_d;
  logic               defer;

  assign defer = align_defers(trace_en, trace_align);

  always_comb begin
    state_d  = state;
    pend_d   = pend;
    brk_now  = 1'b0;
    stop_now = 1'b0;
    case (ev)
      EV_ABORT, EV_XTAG: begin
        brk_now  = 1'b1;
        stop_now = trace_en;
        state_d  = S_IDLE;
        pend_d   = 1'b0;
      end
      EV_CLASH: begin
        state_d = S_IDLE;
        pend_d  = 1'b0;
      end
      EV_DONE: begin
        brk_now = 1'b1;
        state_d = S_IDLE;
        pend_d  = 1'b0;
      end
      EV_TRIG: begin
        if (defer) begin
          state_d = S_FINAL;
          pend_d  = 1'b1;
        end else begin
          brk_now  = 1'b1;
          stop_now = trace_en;
          state_d  = S_IDLE;
        end
      end
      EV_STEP: begin
        if (state < S_LAST) state_d = state + 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      pend  <= 1'b0;
    end else begin
      state <= state_d;
      pend  <= pend_d;
    end
  end

endmodule

// File: rtl/dbgarb_route.sv
module dbgarb_route
  import dbgarb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic brk_now,
  input  logic stop_now,
  input  logic brk_en,
  input  logic brk_to_mon,
  input  logic mon_enabled,
  input  logic mon_active,
  output logic mon_req,
  output logic swi_req,
  output logic trace_stop
);

  route_e route;
  assign route = route_brk(brk_en, brk_to_mon, mon_enabled, mon_active);

  always_ff @(posedge clk) begin
    if (rst) begin
      mon_req    <= 1'b0;
      swi_req    <= 1'b0;
      trace_stop <= 1'b0;
    end else begin
      mon_req    <= brk_now && (route == ROUTE_MON);
      swi_req    <= brk_now && (route == ROUTE_SWI);
      trace_stop <= stop_now;
    end
  end

endmodule

// File: rtl/dbg_session_arb.sv
module dbg_session_arb
  import dbgarb_pkg::*;
#(
  parameter int N_CH    = 4,
  parameter int STATE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm,
  input  logic               seq_step,
  input  logic [N_CH-1:0]    comp_trig,
  input  logic [N_CH-1:0]    comp_tag,
  input  logic               sw_trig,
  input  logic               ext_tag_hi,
  input  logic               ext_tag_lo,
  input  logic               cop_brk,
  input  logic               trace_en,
  input  logic [1:0]         trace_align,
  input  logic               trace_done,
  input  logic               brk_en,
  input  logic               brk_to_mon,
  input  logic               mon_enabled,
  input  logic               mon_active,
  output logic               mon_req,
  output logic               swi_req,
  output logic               trace_stop,
  output logic [STATE_W-1:0] seq_state
);

  logic   ext_tag;
  logic   pend;
  logic   brk_now;
  logic   stop_now;
  event_e ev;

  assign ext_tag = ext_tag_hi | ext_tag_lo;

  dbgarb_resolve #(.N_CH(N_CH)) u_resolve (
    .arm        (arm),
    .seq_step   (seq_step),
    .comp_trig  (comp_trig),
    .comp_tag   (comp_tag),
    .sw_trig    (sw_trig),
    .ext_tag    (ext_tag),
    .cop_brk    (cop_brk),
    .trace_done (trace_done),
    .pend       (pend),
    .ev         (ev)
  );

  dbgarb_seq #(.STATE_W(STATE_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .ev          (ev),
    .trace_en    (trace_en),
    .trace_align (trace_align),
    .state       (seq_state),
    .pend        (pend),
    .brk_now     (brk_now),
    .stop_now    (stop_now)
  );

  dbgarb_route u_route (
    .clk         (clk),
    .rst         (rst),
    .brk_now     (brk_now),
    .stop_now    (stop_now),
    .brk_en      (brk_en),
    .brk_to_mon  (brk_to_mon),
    .mon_enabled (mon_enabled),
    .mon_active  (mon_active),
    .mon_req     (mon_req),
    .swi_req     (swi_req),
    .trace_stop  (trace_stop)
  );

endmodule

// File: rtl/dbgarb_chk.sv
module dbgarb_chk #(
  parameter int STATE_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               ext_tag_hi,
  input logic               ext_tag_lo,
  input logic               cop_brk,
  input logic               trace_en,
  input logic               trace_done,
  input logic               brk_en,
  input logic               brk_to_mon,
  input logic               mon_active,
  input logic               pend,
  input logic               mon_req,
  input logic               swi_req,
  input logic               trace_stop,
  input logic [STATE_W-1:0] seq_state
);

  localparam logic [STATE_W-1:0] S_FINAL = '1;

  assert_req_excl_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mon_req, swi_req}));

  assert_mon_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    $past(mon_active) |-> !(mon_req || swi_req));

  assert_brk_off_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!brk_en) |-> !(mon_req || swi_req));

  assert_xtag_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (ext_tag_hi || ext_tag_lo) |=> (seq_state == '0));

  assert_final_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (pend && !trace_done && !ext_tag_hi && !ext_tag_lo && !cop_brk)
      |=> (seq_state == S_FINAL));

  assert_cop_swi_R9: assert property (@(posedge clk) disable iff (rst)
    (cop_brk && brk_en && !brk_to_mon && !mon_active) |=> swi_req);

  assert_stop_trace_R3: assert property (@(posedge clk) disable iff (rst)
    trace_stop |-> $past(trace_en));

endmodule

bind dbg_session_arb dbgarb_chk #(.STATE_W(STATE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ext_tag_hi (ext_tag_hi),
  .ext_tag_lo (ext_tag_lo),
  .cop_brk    (cop_brk),
  .trace_en   (trace_en),
  .trace_done (trace_done),
  .brk_en     (brk_en),
  .brk_to_mon (brk_to_mon),
  .mon_active (mon_active),
  .pend       (pend),
  .mon_req    (mon_req),
  .swi_req    (swi_req),
  .trace_stop (trace_stop),
  .seq_state  (seq_state)
);

// File: tb/tb_dbg_session_arb.sv
module tb_dbg_session_arb;

  localparam int N_CH    = 4;
  localparam int STATE_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0, seq_step = 1'b0, sw_trig = 1'b0;
  logic [N_CH-1:0] comp_trig = '0, comp_tag = '0;
  logic ext_tag_hi = 1'b0, ext_tag_lo = 1'b0, cop_brk = 1'b0;
  logic trace_en = 1'b0, trace_done = 1'b0;
  logic [1:0] trace_align = 2'b00;
  logic brk_en = 1'b0, brk_to_mon = 1'b0, mon_enabled = 1'b0, mon_active = 1'b0;
  logic mon_req, swi_req, trace_stop;
  logic [STATE_W-1:0] seq_state;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dbg_session_arb #(.N_CH(N_CH), .STATE_W(STATE_W)) dut (
    .clk(clk), .rst(rst), .arm(arm), .seq_step(seq_step),
    .comp_trig(comp_trig), .comp_tag(comp_tag), .sw_trig(sw_trig),
    .ext_tag_hi(ext_tag_hi), .ext_tag_lo(ext_tag_lo), .cop_brk(cop_brk),
    .trace_en(trace_en), .trace_align(trace_align), .trace_done(trace_done),
    .brk_en(brk_en), .brk_to_mon(brk_to_mon), .mon_enabled(mon_enabled),
    .mon_active(mon_active), .mon_req(mon_req), .swi_req(swi_req),
    .trace_stop(trace_stop), .seq_state(seq_state)
  );

  // Fields: [11] brk_en [10] brk_to_mon [9] mon_enabled [8] mon_active
  // [7] trace_en [6:5] trace_align | expected [4] mon_req [3] swi_req
  // [2] trace_stop [1:0] seq_state, one cycle after an sw_trig pulse.
  localparam logic [11:0] VECS [0:9] = '{
    12'b0000_0_00_0_0_0_00,  // R10 disabled
    12'b1000_0_00_0_1_0_00,  // R10 to swi
    12'b1100_0_00_0_1_0_00,  // R10 monitor not enabled
    12'b1110_0_00_1_0_0_00,  // R10 monitor entry
    12'b1111_0_00_0_0_0_00,  // R11 monitor active
    12'b1001_0_00_0_0_0_00,  // R11 active also blocks swi
    12'b1000_1_00_0_1_1_00,  // R3 end aligned
    12'b1000_1_11_0_1_1_00,  // R3 code 11 as end
    12'b1110_1_01_0_0_0_11,  // R4 begin defers
    12'b1110_0_10_1_0_0_00   // R3 mid but no tracing
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    act = {mon_req, swi_req, trace_stop, seq_state};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick();
    do_reset();
    chk("R1 reset state", 5'b00000);

    // Mapping and alignment sweep; unit disarmed, so sw_trig alone acts (R5).
    for (int i = 0; i < 10; i++) begin
      do_reset();
      {brk_en, brk_to_mon, mon_enabled, mon_active, trace_en, trace_align} = VECS[i][11:5];
      sw_trig = 1'b1;
      tick();
      sw_trig = 1'b0;
      chk($sformatf("R10 vector %0d", i), VECS[i][4:0]);
    end

    // R12: a request lasts one cycle.
    do_reset();
    brk_en = 1'b1; brk_to_mon = 1'b0; mon_enabled = 1'b0; mon_active = 1'b0;
    trace_en = 1'b0; trace_align = 2'b00;
    sw_trig = 1'b1; tick(); sw_trig = 1'b0;
    chk("R12 request raised", 5'b01000);
    tick();
    chk("R12 request single cycle", 5'b00000);

    // R5: disarmed comparator trigger ignored.
    comp_trig = 4'b0100; tick(); comp_trig = '0;
    chk("R5 disarmed comparator", 5'b00000);

    // R2: stepping.
    arm = 1'b1;
    seq_step = 1'b1; tick(); seq_step = 1'b0;
    chk("R2 step to 1", 5'b00001);
    seq_step = 1'b1; tick(); seq_step = 1'b0;
    chk("R2 step to 2", 5'b00010);
    seq_step = 1'b1; tick(); seq_step = 1'b0;
    chk("R2 saturate at 2", 5'b00010);
    arm = 1'b0;
    seq_step = 1'b1; tick(); seq_step = 1'b0;
    chk("R2 disarmed step ignored", 5'b00010);

    // R8: comparator tag and external tag together.
    arm = 1'b1;
    comp_tag = 4'b1000; ext_tag_lo = 1'b1; tick();
    comp_tag = '0; ext_tag_lo = 1'b0;
    chk("R8 clash to idle", 5'b00000);

    // R4 / R6: begin aligned deferral with a comparator trigger.
    trace_en = 1'b1; trace_align = 2'b01;
    trace_done = 1'b1; tick(); trace_done = 1'b0;
    chk("R4 stray trace_done", 5'b00000);
    comp_trig = 4'b0010; tick(); comp_trig = '0;
    chk("R4 enter final", 5'b00011);
    tick();
    chk("R4 hold final", 5'b00011);
    sw_trig = 1'b1; tick(); sw_trig = 1'b0;
    chk("R6 sw_trig ignored", 5'b00011);
    comp_trig = 4'b0001; tick(); comp_trig = '0;
    chk("R6 comparator ignored", 5'b00011);
    trace_done = 1'b1; tick(); trace_done = 1'b0;
    chk("R4 break after trace", 5'b01000);

    // R7: external tag ends a mid aligned pending session.
    trace_align = 2'b10;
    sw_trig = 1'b1; tick(); sw_trig = 1'b0;
    chk("R4 mid enter final", 5'b00011);
    ext_tag_hi = 1'b1; tick(); ext_tag_hi = 1'b0;
    chk("R7 tag ends pending", 5'b01100);
    trace_align = 2'b01;
    ext_tag_lo = 1'b1; tick(); ext_tag_lo = 1'b0;
    chk("R7 tag end aligned", 5'b01100);

    // R9: coprocessor breakpoint beats everything, clears pending.
    brk_to_mon = 1'b1; mon_enabled = 1'b1;
    sw_trig = 1'b1; tick(); sw_trig = 1'b0;
    chk("R4 pending again", 5'b00011);
    cop_brk = 1'b1; ext_tag_hi = 1'b1; comp_tag = 4'b0001; sw_trig = 1'b1;
    tick();
    cop_brk = 1'b0; ext_tag_hi = 1'b0; comp_tag = '0; sw_trig = 1'b0;
    chk("R9 cop wins", 5'b10100);
    trace_done = 1'b1; tick(); trace_done = 1'b0;
    chk("R9 pending cleared", 5'b00000);

    // R1: reset discards a pending breakpoint.
    sw_trig = 1'b1; tick(); sw_trig = 1'b0;
    chk("R1 pending before reset", 5'b00011);
    do_reset();
    chk("R1 reset to idle", 5'b00000);
    trace_done = 1'b1; tick(); trace_done = 1'b0;
    chk("R1 pending discarded", 5'b00000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule